// File: doc/BRIEF.md
# Paged RAM Address Translator

This block sits between a CPU and its RAM. It turns logical addresses that fall in the low 4 MB window into physical addresses through a table of 1024 page entries held on chip. Each entry is 16 bits wide. The low ten bits of an entry give the physical page frame, and two status bits record whether the page has been touched or written. Every translated access looks up the entry and returns the frame joined to the 12-bit page offset, one clock after the request. In the same clock the block sets the page's accessed or dirty marks, but only for pages whose status field is already non-zero.

Addresses at or above the 4 MB window leave the block unchanged. A second port lets the CPU read and write table entries as ordinary big-endian memory in a 64 KB slot. While the boot-time low-map enable is clear, both ports force address bit 23 high. Every CPU access then lands in the ROM region, and the table slot cannot be reached.

Top module: `page_xlate_unit`

## Requirements
- R1: When `cpu_req` is high and the effective address is below 0x400000, the block drives `xl_valid` = 1, `xl_mapped` = 1 and `xl_addr` = {2'b00, entry[9:0], addr[11:0]} in the following cycle. `entry` is the table word selected before this access updates it.
- R2: When `cpu_req` is high and the effective address is 0x400000 or above, the block drives `xl_valid` = 1, `xl_mapped` = 0 and `xl_addr` equal to the effective address in the following cycle. When `cpu_req` is low, `xl_valid` is 0 in the following cycle.
- R3: The table index is logical address bits 21:12. Pages 0 and 1023 both translate.
- R4: If entry bits 14:13 are 00, a translated access leaves the entry unchanged.
- R5: If entry bits 14:13 are non-zero, a translated read sets bit 14 and leaves every other bit unchanged.
- R6: If entry bits 14:13 are non-zero, a translated write sets bits 14 and 13 and leaves every other bit unchanged.
- R7: The table port responds to bus addresses 0x400000 to 0x40FFFF. The entry is selected by address bits 10:1, so the whole slot aliases onto the 2 KB table. The port is big-endian: `map_be[1]` (the even byte) writes bits 15:8 and `map_be[0]` writes bits 7:0. A read returns the whole entry on `map_rdata` in the following cycle.
- R8: While `romlow_en` is 0, both ports OR address bit 23 in before decoding. CPU accesses then pass through untranslated with bit 23 set, and table-port accesses do not reach the table.
- R9: When a table-port write and a status update target the same entry in the same cycle, the port write is stored and the status update is dropped.
- R10: Table-port accesses outside the slot have no effect on any entry.
- R11: While reset is asserted, `xl_valid`, `xl_mapped`, `xl_addr` and `map_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| romlow_en | input | 1 | Low-map enable; 0 forces address bit 23 high |
| cpu_req | input | 1 | Translation request strobe |
| cpu_wr | input | 1 | Request is a write |
| cpu_addr | input | 24 | Logical address |
| xl_valid | output | 1 | Result valid (one cycle after request) |
| xl_mapped | output | 1 | Result went through the table |
| xl_addr | output | 24 | Physical or passed-through address |
| map_req | input | 1 | Table port strobe |
| map_we | input | 1 | Table port write |
| map_addr | input | 24 | Table port bus address |
| map_be | input | 2 | Byte enables, bit 1 = even byte = bits 15:8 |
| map_wdata | input | 16 | Table port write data |
| map_rdata | output | 16 | Table port read data |

## Verification
The assertions assume that every table entry a translated access touches was written through the table port beforehand, so that no lookup returns an undefined word. The status-bit checks also assume no table-port write happens in the same cycle as the translated access. The bench writes every entry it uses before it translates through that entry. The same-cycle port write and status update is exercised once, in a dedicated step, and that step is checked only through the port values.

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int ADDR_W  = 24,
  parameter int PAGE_W  = 10,
  parameter int OFS_W   = 12,
  parameter int ENT_W   = 16,
  parameter int SLOT_LO = 16,
  parameter logic [ADDR_W-SLOT_LO-1:0] MAP_SLOT = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              romlow_en,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              xl_valid,
  output logic              xl_mapped,
  output logic [ADDR_W-1:0] xl_addr,
  input  logic              map_req,
  input  logic              map_we,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [1:0]        map_be,
  input  logic [ENT_W-1:0]  map_wdata,
  output logic [ENT_W-1:0]  map_rdata
);
  localparam int PHYS_W  = PAGE_W + OFS_W;
  localparam int ENTRIES = 1 << PAGE_W;
  localparam int ST_HI   = 14;
  localparam int ST_LO   = 13;
  localparam logic [ADDR_W-1:0] ROM_BIT = ADDR_W'(1) << (ADDR_W-1);

  logic [ENT_W-1:0] map_mem [ENTRIES];

  logic [ADDR_W-1:0] eff_cpu, eff_map;
  logic [PAGE_W-1:0] page, map_idx;
  logic [ENT_W-1:0]  cur, upd_val;
  logic              below, st_nz, map_hit, map_wr, upd;

  assign eff_cpu = romlow_en ? cpu_addr : (cpu_addr | ROM_BIT);
  assign eff_map = romlow_en ? map_addr : (map_addr | ROM_BIT);
  assign below   = (eff_cpu[ADDR_W-1:PHYS_W] == '0);
  assign page    = eff_cpu[PHYS_W-1:OFS_W];
  assign cur     = map_mem[page];
  assign st_nz   = |cur[ST_HI:ST_LO];

  assign map_hit = map_req && (eff_map[ADDR_W-1:SLOT_LO] == MAP_SLOT);
  assign map_idx = eff_map[PAGE_W:1];
  assign map_wr  = map_hit && map_we;

  assign upd     = cpu_req && below && st_nz && !(map_wr && (map_idx == page));
  always_comb begin
    upd_val        = cur;
    upd_val[ST_HI] = 1'b1;
    if (cpu_wr) upd_val[ST_LO] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (map_wr) begin
      if (map_be[1]) map_mem[map_idx][ENT_W-1:ENT_W/2] <= map_wdata[ENT_W-1:ENT_W/2];
      if (map_be[0]) map_mem[map_idx][ENT_W/2-1:0]     <= map_wdata[ENT_W/2-1:0];
    end
    if (upd) map_mem[page] <= upd_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_valid  <= 1'b0;
      xl_mapped <= 1'b0;
      xl_addr   <= '0;
      map_rdata <= '0;
    end else begin
      xl_valid <= cpu_req;
      if (cpu_req) begin
        xl_mapped <= below;
        xl_addr   <= below ? {{(ADDR_W-PHYS_W){1'b0}}, cur[PAGE_W-1:0], eff_cpu[OFS_W-1:0]}
                           : eff_cpu;
      end
      if (map_hit && !map_we) map_rdata <= map_mem[map_idx];
    end
  end

  // R1
  low_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && below |=> xl_valid && xl_mapped
      && xl_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])
      && xl_addr[ADDR_W-1:PHYS_W] == '0);

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !below |=> xl_valid && !xl_mapped && xl_addr == $past(eff_cpu));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> !xl_valid);

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && below && !st_nz && !map_wr |=> map_mem[$past(page)] == $past(cur));

  // R5
  accessed_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_wr && below && st_nz && !map_wr
      |=> map_mem[$past(page)] == ($past(cur) | 16'h4000));

  // R6
  dirty_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_wr && below && st_nz && !map_wr
      |=> map_mem[$past(page)] == ($past(cur) | 16'h6000));

  // R8
  rom_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !romlow_en |=> !xl_mapped && xl_addr[ADDR_W-1]);

  // R11
  always_ff @(posedge clk) begin
    if (!rst_n && $past(!rst_n)) begin
      reset_clear_chk: assert (!xl_valid && !xl_mapped && xl_addr == '0 && map_rdata == '0);
    end
  end
endmodule

// File: tb/sim_page_xlate_unit.sv
module sim_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        romlow_en = 1'b0;
  logic        cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        xl_valid, xl_mapped;
  logic [23:0] xl_addr;
  logic        map_req = 1'b0, map_we = 1'b0;
  logic [23:0] map_addr = '0;
  logic [1:0]  map_be = '0;
  logic [15:0] map_wdata = '0;
  logic [15:0] map_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed { logic [23:0] a; logic m; logic [7:0] tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  page_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .romlow_en(romlow_en),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .xl_valid(xl_valid), .xl_mapped(xl_mapped), .xl_addr(xl_addr),
    .map_req(map_req), .map_we(map_we), .map_addr(map_addr),
    .map_be(map_be), .map_wdata(map_wdata), .map_rdata(map_rdata)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && !done && xl_valid) begin
      if (sb.size() == 0) chk(1'b0, "R2 unexpected result", {7'd0, xl_mapped, xl_addr}, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(xl_addr == e.a && xl_mapped == e.m, $sformatf("R%0d translate", e.tag),
            {7'd0, xl_mapped, xl_addr}, {7'd0, e.m, e.a});
      end
    end
  end

  // driver: leaves the request up until the next call or cpu_idle
  task automatic cpu_acc(logic [23:0] a, bit wr, logic [23:0] ea, bit em, logic [7:0] tag);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
    sb.push_back('{a: ea, m: em, tag: tag});
  endtask

  task automatic cpu_idle();
    @(negedge clk);
    cpu_req = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic map_write(logic [23:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    map_req = 1'b1; map_we = 1'b1; map_addr = a; map_be = be; map_wdata = d;
    @(negedge clk);
    map_req = 1'b0; map_we = 1'b0;
  endtask

  task automatic map_check(logic [23:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    map_req = 1'b1; map_we = 1'b0; map_addr = a;
    @(negedge clk);
    map_req = 1'b0;
    chk(map_rdata == exp, req, {16'h0, map_rdata}, {16'h0, exp});
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!xl_valid && !xl_mapped && xl_addr == 0, "R11 xl outputs", {7'd0, xl_mapped, xl_addr}, 0);
    chk(map_rdata == 0, "R11 map_rdata", {16'h0, map_rdata}, 0);
    @(negedge clk); rst_n = 1'b1;

    romlow_en = 1'b1;
    map_write(24'h400000, 2'b11, 16'h0000);
    // R8: override on, table unreachable, CPU goes to ROM
    romlow_en = 1'b0;
    map_write(24'h400000, 2'b11, 16'hFFFF);
    cpu_acc(24'h000ABC, 1'b0, 24'h800ABC, 1'b0, 8);
    cpu_idle();
    romlow_en = 1'b1;
    map_check(24'h400000, 16'h0000, "R8 table untouched");

    // R1 R5: accessed mark on read
    map_write(24'h40000A, 2'b11, 16'h2123);
    cpu_acc(24'h005ABC, 1'b0, 24'h123ABC, 1'b1, 1);
    cpu_idle();
    map_check(24'h40000A, 16'h6123, "R5 accessed bit");

    // R4: zero status leaves entry alone
    map_write(24'h40000E, 2'b11, 16'h0055);
    cpu_acc(24'h007010, 1'b1, 24'h055010, 1'b1, 4);
    cpu_idle();
    map_check(24'h40000E, 16'h0055, "R4 entry unchanged");

    // R3 R6: last page, dirty mark on write
    map_write(24'h4007FE, 2'b11, 16'h4200);
    cpu_acc(24'h3FFFFF, 1'b1, 24'h200FFF, 1'b1, 3);
    cpu_idle();
    map_check(24'h4007FE, 16'h6200, "R6 dirty bits");

    // R2: pass-through region
    cpu_acc(24'h400000, 1'b0, 24'h400000, 1'b0, 2);
    cpu_acc(24'h7ABCDE, 1'b1, 24'h7ABCDE, 1'b0, 2);
    cpu_acc(24'hFFFFFF, 1'b0, 24'hFFFFFF, 1'b0, 2);
    // R1 R3: back-to-back, page 0 frame 0
    cpu_acc(24'h000123, 1'b0, 24'h000123, 1'b1, 3);
    cpu_acc(24'h005004, 1'b1, 24'h123004, 1'b1, 1);
    cpu_idle();
    map_check(24'h40000A, 16'h6123, "R6 status already set");

    // R7: alias and byte lanes
    map_write(24'h40F80A, 2'b10, 16'hAB00);
    map_check(24'h40000A, 16'hAB23, "R7 even byte alias");
    map_write(24'h40000B, 2'b01, 16'h00CD);
    map_check(24'h40F00A, 16'hABCD, "R7 odd byte");

    // R10: outside the slot
    map_write(24'h410000, 2'b11, 16'h1111);
    map_check(24'h400000, 16'h0000, "R10 ignored write");

    // R9: same-cycle port write wins over status update
    map_write(24'h400012, 2'b11, 16'h2009);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 24'h009000;
    sb.push_back('{a: 24'h009000, m: 1'b1, tag: 9});
    map_req = 1'b1; map_we = 1'b1; map_addr = 24'h400012; map_be = 2'b11; map_wdata = 16'h0111;
    @(negedge clk);
    cpu_req = 1'b0; map_req = 1'b0; map_we = 1'b0;
    map_check(24'h400012, 16'h0111, "R9 port write priority");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 results outstanding", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule